// File: doc/BRIEF.md
# Passcode-Locked Fuse Register Front End

This block is the register slave that sits in front of a one-time-programmable fuse array. Software reaches it over an APB-style bus with 32-bit word accesses. Every register except the lock word refuses writes until a fixed passcode has been written to the lock word. Writing any other value to the lock word locks the block again.

A small interrupt unit collects the events of the block. It has a write-1-to-clear status word, a read-only mask word, and a pair of set/clear ports that are the only way to change the mask. The unit drives one level-sensitive interrupt line.

The read path takes a page/row address from a register write. It fetches the row through a synchronous row-read port and leaves the word in a data register. Rows that hold secret key material are never fetched: the read returns zero and raises a sticky error flag. A bank of fuse timing words is kept as plain storage with fixed reset values.

Top module: `fuse_regfront`

## Requirements
- R1: After reset the block reads as follows.
  - Lock word (index 0, byte offset 0x00) reads 1.
  - Status word (0x04) reads 0.
  - Mask word (0x08) reads 0x80007FFF.
  - Row data word (0x18) reads 0.
  - The six timing words at 0x1C, 0x20, 0x24, 0x28, 0x2C and 0x30 read 0x19, 0xFF, 0x11, 0x3A, 0x16 and 0x08.
  - The interrupt line is low.
- R2: A write of exactly 0x0000DF0D to the lock word makes it read 0. A write of any other 32-bit value makes it read 1. Writes to the lock word are accepted whether it is locked or not.
- R3: While the lock word reads 1, a write to any other offset has no effect. A discarded write to the row address word starts no fetch and completes with no wait state.
- R4: The status word (0x04) clears each bit written with 1, on bits 14:0 and bit 31. Bits 30:15 always read 0. Bit 2 is read-done and bit 3 is read-error. Hardware only sets these bits; they stay set until software clears them.
- R5: The mask word (0x08) ignores writes. A 1 written to a bit of the enable word (0x0C) clears that mask bit. A 1 written to a bit of the disable word (0x10) sets that mask bit. Only bits 14:0 and 31 are affected. The enable word and the disable word both read 0.
- R6: The interrupt line is high exactly when the status word AND the inverted mask word is nonzero. It follows every status, enable, disable and read-completion change on the next cycle.
- R7: A write to the row address word (0x14) starts a fetch of page = wdata[16:13], row = wdata[12:5]. The fetched row word then appears in the row data word (0x18). The row address word reads 0.
- R8: A request for page 0, rows 12 to 35 inclusive, is refused. No fetch is issued, the row data word becomes 0, and status bit 3 is set. Bit 3 stays set across later successful reads.
- R9: Every accepted row request sets status bit 2, whether it was refused or not.
- R10: An accepted write to the row address word completes with exactly one wait state. Every other access completes with none.
- R11: The timing words store wdata[7:0]; their bits 31:8 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer completes in this cycle |
| irq | output | 1 | Level interrupt |
| fz_rd_en | output | 1 | Row fetch request to the fuse array |
| fz_page | output | PAGE_W | Page of the fetched row |
| fz_row | output | ROW_W | Row of the fetched row |
| fz_data | input | 32 | Row word, valid the cycle after fz_rd_en |

## Verification
A read completion sets read-done, and possibly read-error, at the same clock edge at which the interrupt line must move.

The bench provokes this in two ways. First, it unmasks read-done while a done event is already pending. Second, it issues a refused read while only the error source is unmasked. It also issues an allowed read while the error flag is still sticky from an earlier refusal.

A behavioural model updates status, mask and data on each completed transfer. It is compared with the interrupt line on every clock and with every read value and wait count, so any cycle in which the set and the line disagree is reported.

// File: rtl/fuse_regfront_pkg.sv
package fuse_regfront_pkg;

   localparam int REG_W       = 32;
   // word indices (byte offset = index * 4)
   localparam int IDX_LOCK    = 0;
   localparam int IDX_STAT    = 1;
   localparam int IDX_MASK    = 2;
   localparam int IDX_IEN     = 3;
   localparam int IDX_IDIS    = 4;
   localparam int IDX_RADDR   = 5;
   localparam int IDX_RDATA   = 6;
   localparam int IDX_TFIRST  = 7;
   localparam int NUM_TREG    = 6;
   localparam int NUM_IDX     = IDX_TFIRST + NUM_TREG;

   localparam logic [REG_W-1:0] UNLOCK_CODE = 32'h0000_DF0D;

   localparam int ST_RD_DONE  = 2;
   localparam int ST_RD_ERR   = 3;

   typedef logic [7:0] treg_t;

   function automatic treg_t treg_reset(input int i);
      case (i)
         0:       return 8'h19;
         1:       return 8'hFF;
         2:       return 8'h11;
         3:       return 8'h3A;
         4:       return 8'h16;
         default: return 8'h08;
      endcase
   endfunction

endpackage

// File: rtl/frf_access_gate.sv
module frf_access_gate
   import fuse_regfront_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                psel,
   input  logic                penable,
   input  logic                pwrite,
   input  logic [ADDR_W-1:0]   paddr,
   input  logic [REG_W-1:0]    pwdata,
   output logic                lock_o,
   output logic [ADDR_W-3:0]   idx_o,
   output logic [NUM_IDX-1:0]  wr_sel_o
);
   localparam int IDX_W = ADDR_W - 2;

   logic lock_q;
   logic wr_acc;
   logic unused_lsb;

   initial assert ((1 << IDX_W) >= NUM_IDX);

   assign unused_lsb = ^paddr[1:0];
   assign idx_o      = paddr[ADDR_W-1:2];
   assign wr_acc     = psel & penable & pwrite;
   assign lock_o     = lock_q;

   for (genvar i = 0; i < NUM_IDX; i++) begin : g_sel
      if (i == IDX_LOCK) begin : g_lockword
         assign wr_sel_o[i] = wr_acc && (idx_o == IDX_W'(i));
      end else begin : g_gated
         assign wr_sel_o[i] = wr_acc && (idx_o == IDX_W'(i)) && !lock_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  lock_q <= 1'b1;
      else if (wr_sel_o[IDX_LOCK]) lock_q <= (pwdata != UNLOCK_CODE);
   end

   p_unlock_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && idx_o == IDX_W'(IDX_LOCK) && pwdata == UNLOCK_CODE) |=> !lock_o);

endmodule

// File: rtl/frf_irq_block.sv
module frf_irq_block
   import fuse_regfront_pkg::*;
#(
   parameter int NSRC = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stat_i,
   input  logic             wr_en_i,
   input  logic             wr_dis_i,
   input  logic [REG_W-1:0] wdata_i,
   input  logic             set_done_i,
   input  logic             set_err_i,
   output logic [REG_W-1:0] stat_o,
   output logic [REG_W-1:0] mask_o,
   output logic             irq_o
);
   localparam logic [REG_W-1:0] IMPL = {1'b1, {(REG_W-1-NSRC){1'b0}}, {NSRC{1'b1}}};

   logic [REG_W-1:0] stat_q, mask_q, hw_set, w1c;

   initial assert (NSRC > ST_RD_ERR && NSRC < REG_W - 1);

   always_comb begin
      hw_set = '0;
      hw_set[ST_RD_DONE] = set_done_i;
      hw_set[ST_RD_ERR]  = set_err_i;
      w1c = wr_stat_i ? (wdata_i & IMPL) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         mask_q <= IMPL;
      end else begin
         stat_q <= (stat_q & ~w1c) | hw_set;
         if (wr_en_i)       mask_q <= mask_q & ~(wdata_i & IMPL);
         else if (wr_dis_i) mask_q <= mask_q | (wdata_i & IMPL);
      end
   end

   assign stat_o = stat_q;
   assign mask_o = mask_q;
   assign irq_o  = |(stat_q & ~mask_q);

   p_mask_ro_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i || wr_dis_i) |=> $stable(mask_o));
   p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_o[ST_RD_ERR] && !wr_stat_i) |=> stat_o[ST_RD_ERR]);

endmodule

// File: rtl/frf_row_reader.sv
module frf_row_reader
   import fuse_regfront_pkg::*;
#(
   parameter int PAGE_W    = 4,
   parameter int ROW_W     = 8,
   parameter bit BLOCK_EN  = 1'b1,
   parameter int BLK_PAGE  = 0,
   parameter int BLK_FIRST = 12,
   parameter int BLK_LAST  = 35
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [PAGE_W-1:0] page_i,
   input  logic [ROW_W-1:0]  row_i,
   input  logic [REG_W-1:0]  fz_data_i,
   output logic              fz_rd_en_o,
   output logic [PAGE_W-1:0] fz_page_o,
   output logic [ROW_W-1:0]  fz_row_o,
   output logic              hold_o,
   output logic              done_o,
   output logic              err_o,
   output logic [REG_W-1:0]  data_o
);
   logic wait_q, blk_q, blocked, start;
   logic [REG_W-1:0] data_q;

   initial assert (BLK_FIRST <= BLK_LAST && BLK_LAST < (1 << ROW_W));

   if (BLOCK_EN) begin : g_guard
      assign blocked = (page_i == PAGE_W'(BLK_PAGE))
                    && (row_i >= ROW_W'(BLK_FIRST))
                    && (row_i <= ROW_W'(BLK_LAST));
   end else begin : g_open
      assign blocked = 1'b0;
   end

   assign start      = req_i & ~wait_q;
   assign hold_o     = start;
   assign fz_rd_en_o = start & ~blocked;
   assign fz_page_o  = page_i;
   assign fz_row_o   = row_i;
   assign done_o     = wait_q;
   assign err_o      = wait_q & blk_q;
   assign data_o     = data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_q <= 1'b0;
         blk_q  <= 1'b0;
         data_q <= '0;
      end else if (wait_q) begin
         wait_q <= 1'b0;
         data_q <= blk_q ? '0 : fz_data_i;
      end else if (start) begin
         wait_q <= 1'b1;
         blk_q  <= blocked;
      end
   end

   p_fetch_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fz_rd_en_o |=> (done_o && !hold_o));
   p_blocked_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> (data_o == '0));

endmodule

// File: rtl/fuse_regfront.sv
module fuse_regfront
   import fuse_regfront_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int PAGE_W    = 4,
   parameter int ROW_W     = 8,
   parameter int PAGE_LSB  = 13,
   parameter int ROW_LSB   = 5,
   parameter int NSRC      = 15,
   parameter bit BLOCK_EN  = 1'b1,
   parameter int BLK_FIRST = 12,
   parameter int BLK_LAST  = 35
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [31:0]       pwdata,
   output logic [31:0]       prdata,
   output logic              pready,
   output logic              irq,
   output logic              fz_rd_en,
   output logic [PAGE_W-1:0] fz_page,
   output logic [ROW_W-1:0]  fz_row,
   input  logic [31:0]       fz_data
);
   localparam int IDX_W = ADDR_W - 2;

   logic               lock_q;
   logic [IDX_W-1:0]   idx;
   logic [NUM_IDX-1:0] wr_sel;
   logic [REG_W-1:0]   stat, mask, row_data;
   logic               hold, rd_done, rd_err;
   treg_t              treg_q [NUM_TREG];

   initial assert (PAGE_LSB + PAGE_W <= REG_W && ROW_LSB + ROW_W <= PAGE_LSB);

   frf_access_gate #(.ADDR_W(ADDR_W)) u_gate (
      .clk(pclk), .rst_n(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
      .lock_o(lock_q), .idx_o(idx), .wr_sel_o(wr_sel)
   );

   frf_irq_block #(.NSRC(NSRC)) u_irq (
      .clk(pclk), .rst_n(presetn),
      .wr_stat_i(wr_sel[IDX_STAT]), .wr_en_i(wr_sel[IDX_IEN]),
      .wr_dis_i(wr_sel[IDX_IDIS]), .wdata_i(pwdata),
      .set_done_i(rd_done), .set_err_i(rd_err),
      .stat_o(stat), .mask_o(mask), .irq_o(irq)
   );

   frf_row_reader #(
      .PAGE_W(PAGE_W), .ROW_W(ROW_W), .BLOCK_EN(BLOCK_EN),
      .BLK_PAGE(0), .BLK_FIRST(BLK_FIRST), .BLK_LAST(BLK_LAST)
   ) u_rd (
      .clk(pclk), .rst_n(presetn), .req_i(wr_sel[IDX_RADDR]),
      .page_i(pwdata[PAGE_LSB +: PAGE_W]), .row_i(pwdata[ROW_LSB +: ROW_W]),
      .fz_data_i(fz_data), .fz_rd_en_o(fz_rd_en), .fz_page_o(fz_page),
      .fz_row_o(fz_row), .hold_o(hold), .done_o(rd_done), .err_o(rd_err),
      .data_o(row_data)
   );

   for (genvar t = 0; t < NUM_TREG; t++) begin : g_treg
      always_ff @(posedge pclk or negedge presetn) begin
         if (!presetn)                  treg_q[t] <= treg_reset(t);
         else if (wr_sel[IDX_TFIRST+t]) treg_q[t] <= pwdata[7:0];
      end
   end

   assign pready = ~hold;

   always_comb begin
      prdata = '0;
      if (psel && !pwrite) begin
         if (idx == IDX_W'(IDX_LOCK))       prdata = {31'b0, lock_q};
         else if (idx == IDX_W'(IDX_STAT))  prdata = stat;
         else if (idx == IDX_W'(IDX_MASK))  prdata = mask;
         else if (idx == IDX_W'(IDX_RDATA)) prdata = row_data;
         for (int t = 0; t < NUM_TREG; t++)
            if (idx == IDX_W'(IDX_TFIRST + t)) prdata = {24'b0, treg_q[t]};
      end
   end

   p_lock_hold_r3: assert property (@(posedge pclk) disable iff (!presetn)
      (lock_q && psel && penable && pwrite && idx == IDX_W'(IDX_TFIRST))
      |=> $stable(treg_q[0]));
   p_done_set_r9: assert property (@(posedge pclk) disable iff (!presetn)
      rd_done |=> stat[ST_RD_DONE]);

endmodule

// File: tb/tb_fuse_regfront.sv
module tb_fuse_regfront;
   logic        clk = 1'b0;
   logic        presetn = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [7:0]  paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        pready, irq, fz_rd_en;
   logic [3:0]  fz_page;
   logic [7:0]  fz_row;
   logic [31:0] fz_data = '0;

   int checks = 0, fails = 0, fetches = 0;
   bit run = 1'b0;

   // behavioural reference state
   int unsigned m_lock, m_stat, m_mask, m_data;
   int unsigned m_treg [6];
   localparam int unsigned IMPL = 32'h8000_7FFF;

   always #2 clk = ~clk;

   fuse_regfront dut (
      .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pready(pready), .irq(irq), .fz_rd_en(fz_rd_en), .fz_page(fz_page),
      .fz_row(fz_row), .fz_data(fz_data)
   );

   function automatic logic [31:0] fuse_word(input int pg, input int rw);
      return 32'h5C00_0000 | 32'(pg << 20) | 32'(rw << 8) | 32'((rw ^ 8'hA3) & 8'hFF);
   endfunction

   // synchronous fuse array
   always @(posedge clk) if (fz_rd_en) begin
      fz_data <= fuse_word(int'(fz_page), int'(fz_row));
      fetches++;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // R6 compared on every clock
   always @(negedge clk) if (run)
      chk(irq == ((m_stat & ~m_mask) != 0), "R6 irq level", 32'(irq), 32'((m_stat & ~m_mask) != 0));

   function automatic int unsigned m_expect(input int idx);
      case (idx)
         0: return m_lock;
         1: return m_stat;
         2: return m_mask;
         6: return m_data;
         7, 8, 9, 10, 11, 12: return m_treg[idx-7];
         default: return 0;
      endcase
   endfunction

   task automatic m_write(input int idx, input int unsigned wd);
      if (idx == 0) m_lock = (wd != 32'h0000DF0D) ? 1 : 0;
      else if (m_lock == 0) begin
         case (idx)
            1: m_stat = m_stat & ~(wd & IMPL);
            3: m_mask = m_mask & ~(wd & IMPL);
            4: m_mask = m_mask | (wd & IMPL);
            5: begin
               int pg, rw;
               pg = int'((wd >> 13) & 15);
               rw = int'((wd >> 5) & 255);
               if (pg == 0 && rw >= 12 && rw <= 35) begin
                  m_data = 0;
                  m_stat = m_stat | 32'hC;
               end else begin
                  m_data = fuse_word(pg, rw);
                  m_stat = m_stat | 32'h4;
               end
            end
            7, 8, 9, 10, 11, 12: m_treg[idx-7] = wd & 255;
            default: ;
         endcase
      end
   endtask

   task automatic xfer(input logic wr, input logic [7:0] a, input logic [31:0] wd,
                       output logic [31:0] rv, output int waits);
      @(negedge clk);
      psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = wd;
      @(negedge clk);
      penable = 1'b1; waits = 0;
      #1;
      while (!pready) begin
         waits++;
         @(negedge clk);
         #1;
      end
      rv = prdata;
      @(posedge clk);
      #1;
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] wd, input string req);
      logic [31:0] rv;
      int waits, expw;
      expw = (a == 8'h14 && m_lock == 0) ? 1 : 0;
      xfer(1'b1, a, wd, rv, waits);
      chk(waits == expw, {req, " R10 wait count"}, 32'(waits), 32'(expw));
      m_write(int'(a >> 2), wd);
   endtask

   task automatic rd(input logic [7:0] a, input string req);
      logic [31:0] rv;
      int waits;
      int unsigned ev;
      ev = m_expect(int'(a >> 2));
      xfer(1'b0, a, 32'h0, rv, waits);
      chk(rv == ev, req, rv, ev);
      chk(waits == 0, "R10 read wait", 32'(waits), 32'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired act=%0d exp=%0d", checks, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int f0;
      m_lock = 1; m_stat = 0; m_mask = IMPL; m_data = 0;
      m_treg[0] = 'h19; m_treg[1] = 'hFF; m_treg[2] = 'h11;
      m_treg[3] = 'h3A; m_treg[4] = 'h16; m_treg[5] = 'h08;
      repeat (3) @(negedge clk);
      presetn = 1'b1;
      run = 1'b1;

      // R1 reset state
      rd(8'h00, "R1 lock");
      rd(8'h04, "R1 status");
      rd(8'h08, "R1 mask");
      rd(8'h18, "R1 row data");
      for (int i = 0; i < 6; i++) rd(8'(8'h1C + 4*i), "R1 timing reset");

      // R3 writes discarded while locked
      f0 = fetches;
      wr(8'h1C, 32'h0000_00AA, "R3 locked timing");
      rd(8'h1C, "R3 timing unchanged");
      wr(8'h0C, 32'hFFFF_FFFF, "R3 locked enable");
      rd(8'h08, "R3 mask unchanged");
      wr(8'h14, 32'h0000_2020, "R3 locked row addr");
      chk(fetches == f0, "R3 no fetch while locked", 32'(fetches), 32'(f0));
      rd(8'h04, "R3 status unchanged");

      // R2 passcode
      wr(8'h00, 32'h0000_1234, "R2");
      rd(8'h00, "R2 wrong code stays locked");
      wr(8'h00, 32'h0001_DF0D, "R2");
      rd(8'h00, "R2 near code stays locked");
      wr(8'h00, 32'h0000_DF0D, "R2");
      rd(8'h00, "R2 code unlocks");

      // R11 timing storage
      wr(8'h20, 32'hFFFF_FF5A, "R11");
      rd(8'h20, "R11 low byte only");
      wr(8'h30, 32'h0000_0001, "R11");
      rd(8'h30, "R11 test word");

      // R7 R9 R10 allowed read, page 1 row 7
      f0 = fetches;
      wr(8'h14, (32'd1 << 13) | (32'd7 << 5), "R7");
      chk(fetches == f0 + 1, "R7 one fetch", 32'(fetches), 32'(f0 + 1));
      rd(8'h18, "R7 row data");
      rd(8'h04, "R9 done set");
      rd(8'h14, "R7 addr reads zero");

      // R5 R6 unmask done while pending
      wr(8'h0C, 32'h0000_0004, "R5");
      rd(8'h08, "R5 enable clears mask bit");
      rd(8'h0C, "R5 enable reads zero");
      rd(8'h10, "R5 disable reads zero");
      wr(8'h08, 32'h0000_0000, "R5");
      rd(8'h08, "R5 mask ignores write");

      // R4 W1C
      wr(8'h04, 32'h0000_0004, "R4");
      rd(8'h04, "R4 done cleared");

      // R8 refused reads, only error source unmasked
      wr(8'h10, 32'h0000_0004, "R5");
      wr(8'h0C, 32'h0000_0008, "R5");
      f0 = fetches;
      wr(8'h14, (32'd0 << 13) | (32'd12 << 5), "R8 row 12");
      chk(fetches == f0, "R8 no fetch row 12", 32'(fetches), 32'(f0));
      rd(8'h18, "R8 data zero");
      rd(8'h04, "R8 error and done");
      wr(8'h14, (32'd0 << 13) | (32'd36 << 5), "R8 row 36");
      rd(8'h18, "R8 row 36 allowed");
      rd(8'h04, "R8 error sticky");
      f0 = fetches;
      wr(8'h14, (32'd0 << 13) | (32'd35 << 5), "R8 row 35");
      chk(fetches == f0, "R8 no fetch row 35", 32'(fetches), 32'(f0));
      rd(8'h18, "R8 row 35 zero");
      wr(8'h14, (32'd0 << 13) | (32'd11 << 5), "R8 row 11");
      rd(8'h18, "R8 row 11 allowed");
      wr(8'h14, (32'd1 << 13) | (32'd20 << 5), "R8 page 1 row 20");
      rd(8'h18, "R8 other page allowed");

      // R4 R5 reserved bits
      wr(8'h04, 32'hFFFF_FFFF, "R4");
      rd(8'h04, "R4 all cleared");
      wr(8'h0C, 32'hFFFF_FFFF, "R5");
      rd(8'h08, "R5 reserved mask bits zero");
      wr(8'h10, 32'hFFFF_FFFF, "R5");
      rd(8'h08, "R5 disable sets all");

      // R2 R3 relock
      wr(8'h00, 32'h0, "R2");
      rd(8'h00, "R2 relocked");
      f0 = fetches;
      wr(8'h14, (32'd2 << 13), "R3 relocked row");
      chk(fetches == f0, "R3 no fetch relocked", 32'(fetches), 32'(f0));
      rd(8'h18, "R3 data unchanged");

      repeat (3) @(negedge clk);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule